// File: doc/BRIEF.md
# Segment Offset to Linear Address Translator

This block turns a segment-relative offset into a linear address. It keeps six segment slots. Each slot holds a decoded copy of a 64-bit segment descriptor, so the descriptor is fetched only once, when a selector is loaded, and is not fetched again on later accesses. The descriptor fetch is modelled as a plain input port: the caller supplies the 64-bit descriptor together with the slot it goes into. The block has no privilege checks and no overlap checks.

Each access names a slot and gives a 32-bit offset. The block then does three things. It checks that the segment is present. It compares the offset with the segment limit, after scaling the limit by the granularity bit. It adds the 32-bit base, which it rebuilds from three separate descriptor fields. One cycle later it reports the linear address and at most one fault flag. When paging is turned off, the same address is also reported as the physical address.

A descriptor with base zero, the largest limit and page granularity gives a flat model. In that model the linear address equals the offset.

Top module: `segx_translator`

## Requirements
- R1: There are six slots, with indices 0 to 5. A load with `loadValid` high writes the decoded `loadDesc` into slot `loadSlot` at the clock edge. A load naming slot 6 or 7 changes no slot.
- R2: The 32-bit base is rebuilt from three descriptor fields: base[23:0] = desc[39:16] and base[31:24] = desc[63:56].
- R3: The 20-bit limit is {desc[51:48], desc[15:0]}. The granularity bit is desc[55]. When it is 0, the effective limit is the limit itself, a byte count of up to 1 MB. When it is 1, the effective limit is {limit, 12'hFFF}, counted in 4 KB pages.
- R4: `faultLimit` is set when the offset is strictly greater than the effective limit of a present segment. An offset equal to the effective limit is accepted.
- R5: The present bit is desc[47]. An access raises `faultAbsent` in any of three cases: the slot holds a descriptor with this bit clear, the slot was never loaded since reset, or the slot index is 6 or 7. `faultAbsent` takes priority, so the two fault flags are never set together.
- R6: The linear address is base plus offset, modulo 2^32.
- R7: An access with `pagingEn` low and no fault sets `rspPhysValid`, with `rspPhys` equal to the linear address. In every other case `rspPhysValid` and `rspPhys` are 0.
- R8: A response appears exactly one cycle after a request, with `rspValid` high for one cycle. In a cycle with no response, `rspValid`, both fault flags and `rspPhysValid` are low.
- R9: An access in the same cycle as a load to the same slot uses the descriptor the slot held before that load.
- R10: Reset empties every slot and clears all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Load a descriptor into a slot |
| loadSlot | input | 3 | Slot that receives the load |
| loadDesc | input | 64 | Descriptor supplied by the table fetch |
| reqValid | input | 1 | Translation request |
| reqSlot | input | 3 | Slot used by the request |
| reqOffset | input | 32 | Segment-relative offset |
| pagingEn | input | 1 | Paging is on; physical address is not reported |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspLinear | output | 32 | Linear address (base + offset) |
| faultAbsent | output | 1 | Segment not present or slot invalid |
| faultLimit | output | 1 | Offset beyond the effective limit |
| rspPhysValid | output | 1 | Physical address valid |
| rspPhys | output | 32 | Physical address when paging is off |

## Verification
Five slots are loaded with contrasting descriptors:
- a flat page-granular segment;
- a byte-granular segment whose base has bits in both the low and high fields;
- a small page-granular segment;
- a segment that is not present;
- a byte-granular segment whose base is close to 2^32, so the sum wraps.

Offsets sit exactly on the effective limit and one byte past it. These cases separate the byte and page scaling and show whether the base fields were reassembled correctly. An offset past the limit on an absent segment shows which fault wins. Requests with paging on and off separate the linear output from the physical output. Directed tests cover a reload, a load and an access to the same slot in the same cycle, a load to an invalid slot index, and the idle and reset states.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int SLOT_CNT   = 6;
  localparam int SEL_W      = 3;
  localparam int ADDR_W     = 32;
  localparam int DESC_W     = 64;
  localparam int LIM_W      = 20;
  localparam int PAGE_SHIFT = ADDR_W - LIM_W;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] effLim;
    logic              present;
  } segEntry_t;

  typedef struct packed {
    logic             wrEn;
    logic [SEL_W-1:0] wrIdx;
    logic             rdEn;
    logic             rdInRange;
    logic [SEL_W-1:0] rdIdx;
    logic             pageOn;
  } ctlStrobes_t;

  function automatic segEntry_t decodeDesc(input logic [DESC_W-1:0] d);
    segEntry_t e;
    logic [LIM_W-1:0] rawLim;
    rawLim   = {d[51:48], d[15:0]};
    e.base   = {d[63:56], d[39:16]};
    e.effLim = d[55] ? {rawLim, {PAGE_SHIFT{1'b1}}}
                     : {{PAGE_SHIFT{1'b0}}, rawLim};
    e.present = d[47];
    return e;
  endfunction
endpackage

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
#(
  parameter int SLOT_COUNT = SLOT_CNT
) (
  input  logic             loadValid,
  input  logic [SEL_W-1:0] loadSlot,
  input  logic             reqValid,
  input  logic [SEL_W-1:0] reqSlot,
  input  logic             pagingEn,
  output ctlStrobes_t      strobes
);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(SLOT_COUNT - 1);

  always_comb begin
    strobes           = '0;
    strobes.wrEn      = loadValid && (loadSlot <= LAST_IDX);
    strobes.wrIdx     = loadSlot;
    strobes.rdEn      = reqValid;
    strobes.rdInRange = reqSlot <= LAST_IDX;
    strobes.rdIdx     = reqSlot;
    strobes.pageOn    = pagingEn;
  end
endmodule

// File: rtl/segx_datapath.sv
module segx_datapath
  import segx_pkg::*;
#(
  parameter int SLOT_COUNT = SLOT_CNT
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DESC_W-1:0] loadDesc,
  input  logic [ADDR_W-1:0] reqOffset,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspLinear,
  output logic              faultAbsent,
  output logic              faultLimit,
  output logic              rspPhysValid,
  output logic [ADDR_W-1:0] rspPhys
);
  segEntry_t slotQ [SLOT_COUNT];
  segEntry_t newEntry;
  segEntry_t selEntry;
  logic      missNow;
  logic      overNow;
  logic [ADDR_W-1:0] linNow;

  assign newEntry = decodeDesc(loadDesc);

  for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ[g] <= '0;
      end else if (strobes.wrEn && strobes.wrIdx == SEL_W'(g)) begin
        slotQ[g] <= newEntry;
      end
    end
  end

  always_comb begin
    selEntry = '0;
    for (int i = 0; i < SLOT_COUNT; i++) begin
      if (strobes.rdIdx == SEL_W'(i)) selEntry = slotQ[i];
    end
    missNow = !strobes.rdInRange || !selEntry.present;
    overNow = !missNow && (reqOffset > selEntry.effLim);
    linNow  = selEntry.base + reqOffset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspLinear    <= '0;
      faultAbsent  <= 1'b0;
      faultLimit   <= 1'b0;
      rspPhysValid <= 1'b0;
      rspPhys      <= '0;
    end else begin
      rspValid     <= strobes.rdEn;
      rspLinear    <= strobes.rdEn ? linNow : '0;
      faultAbsent  <= strobes.rdEn && missNow;
      faultLimit   <= strobes.rdEn && overNow;
      rspPhysValid <= strobes.rdEn && !missNow && !overNow && !strobes.pageOn;
      rspPhys      <= (strobes.rdEn && !missNow && !overNow && !strobes.pageOn)
                      ? linNow : '0;
    end
  end
endmodule

// File: rtl/segx_translator.sv
module segx_translator
  import segx_pkg::*;
#(
  parameter int SLOT_COUNT = SLOT_CNT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [SEL_W-1:0]  loadSlot,
  input  logic [DESC_W-1:0] loadDesc,
  input  logic              reqValid,
  input  logic [SEL_W-1:0]  reqSlot,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic              pagingEn,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspLinear,
  output logic              faultAbsent,
  output logic              faultLimit,
  output logic              rspPhysValid,
  output logic [ADDR_W-1:0] rspPhys
);
  ctlStrobes_t strobes;

  segx_ctrl #(.SLOT_COUNT(SLOT_COUNT)) i_ctrl (
    .loadValid(loadValid), .loadSlot(loadSlot), .reqValid(reqValid),
    .reqSlot(reqSlot), .pagingEn(pagingEn), .strobes(strobes)
  );

  segx_datapath #(.SLOT_COUNT(SLOT_COUNT)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadDesc(loadDesc),
    .reqOffset(reqOffset), .rspValid(rspValid), .rspLinear(rspLinear),
    .faultAbsent(faultAbsent), .faultLimit(faultLimit),
    .rspPhysValid(rspPhysValid), .rspPhys(rspPhys)
  );
endmodule

// File: rtl/segx_checker.sv
module segx_checker
  import segx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [SEL_W-1:0]  reqSlot,
  input logic              pagingEn,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspLinear,
  input logic              faultAbsent,
  input logic              faultLimit,
  input logic              rspPhysValid,
  input logic [ADDR_W-1:0] rspPhys
);
  // R5
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(faultAbsent && faultLimit));

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!faultAbsent && !faultLimit && !rspPhysValid));

  // R7
  phys_matches_lin_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspPhysValid |-> (rspValid && !faultAbsent && !faultLimit && rspPhys == rspLinear));

  // R7
  paging_blocks_phys_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pagingEn) |=> (!rspPhysValid && rspPhys == '0));

  // R5
  bad_slot_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSlot >= SEL_W'(SLOT_CNT)) |=> faultAbsent);
endmodule

bind segx_translator segx_checker i_segx_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSlot(reqSlot),
  .pagingEn(pagingEn), .rspValid(rspValid), .rspLinear(rspLinear),
  .faultAbsent(faultAbsent), .faultLimit(faultLimit),
  .rspPhysValid(rspPhysValid), .rspPhys(rspPhys)
);

// File: tb/test_segx_translator.sv
module test_segx_translator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadValid = 1'b0;
  logic [2:0]  loadSlot = '0;
  logic [63:0] loadDesc = '0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqSlot = '0;
  logic [31:0] reqOffset = '0;
  logic        pagingEn = 1'b0;
  logic        rspValid, faultAbsent, faultLimit, rspPhysValid;
  logic [31:0] rspLinear, rspPhys;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  segx_translator i_segx_translator (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadSlot(loadSlot),
    .loadDesc(loadDesc), .reqValid(reqValid), .reqSlot(reqSlot),
    .reqOffset(reqOffset), .pagingEn(pagingEn), .rspValid(rspValid),
    .rspLinear(rspLinear), .faultAbsent(faultAbsent), .faultLimit(faultLimit),
    .rspPhysValid(rspPhysValid), .rspPhys(rspPhys)
  );

  typedef struct packed {
    logic [2:0]  slot;
    logic [31:0] off;
    logic        pg;
    logic        ab;
    logic        lf;
    logic [31:0] lin;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R3 flat
    '{3'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF}, // R3 flat max
    '{3'd0, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF}, // R7 paging on
    '{3'd1, 32'h0000_0FFF, 1'b0, 1'b0, 1'b0, 32'h1234_6677}, // R2 R4 at limit
    '{3'd1, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 32'h0},         // R4 past byte limit
    '{3'd2, 32'h0000_2FFF, 1'b0, 1'b0, 1'b0, 32'hA000_2FFF}, // R3 page limit
    '{3'd2, 32'h0000_3000, 1'b0, 1'b0, 1'b1, 32'h0},         // R4 past page limit
    '{3'd3, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h0},         // R5 not present
    '{3'd3, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 32'h0},         // R5 priority
    '{3'd4, 32'h000A_BCDE, 1'b0, 1'b0, 1'b0, 32'h000A_ACDE}, // R6 wrap
    '{3'd4, 32'h000A_BCDF, 1'b1, 1'b0, 1'b1, 32'h0},         // R4 one past
    '{3'd5, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h0},         // R10 unloaded
    '{3'd6, 32'h0000_0010, 1'b0, 1'b1, 1'b0, 32'h0}          // R5 bad slot
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic loadSeg(input logic [2:0] s, input logic [63:0] d);
    @(negedge clk);
    loadValid = 1'b1; loadSlot = s; loadDesc = d;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic access(input logic [2:0] s, input logic [31:0] o, input logic pg);
    @(negedge clk);
    reqValid = 1'b1; reqSlot = s; reqOffset = o; pagingEn = pg;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkRsp(input string tag, input logic ab, input logic lf,
                          input logic pg, input logic [31:0] lin);
    logic ok;
    ok = !ab && !lf;
    chk({tag, " rspValid R8"}, 32'(rspValid), 32'd1);
    chk({tag, " faultAbsent R5"}, 32'(faultAbsent), 32'(ab));
    chk({tag, " faultLimit R4"}, 32'(faultLimit), 32'(lf));
    if (ok) chk({tag, " linear R6"}, rspLinear, lin);
    chk({tag, " physValid R7"}, 32'(rspPhysValid), 32'(ok && !pg));
    chk({tag, " phys R7"}, rspPhys, (ok && !pg) ? lin : 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("reset rspValid R10", 32'(rspValid), 32'd0);
    chk("reset faults R10", 32'({faultAbsent, faultLimit, rspPhysValid}), 32'd0);
    chk("reset phys R10", rspPhys, 32'h0);
    rstN = 1'b1;
    access(3'd0, 32'h0, 1'b0);
    checkRsp("unloaded slot0 R10", 1'b1, 1'b0, 1'b0, 32'h0);

    // R1: fill slots
    loadSeg(3'd0, 64'h008F_8000_0000_FFFF);
    loadSeg(3'd1, 64'h1200_8034_5678_0FFF);
    loadSeg(3'd2, 64'hA080_8000_0000_0002);
    loadSeg(3'd3, 64'h000F_0000_1000_FFFF);
    loadSeg(3'd4, 64'hFF0A_80FF_F000_BCDE);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].slot, VECS[i].off, VECS[i].pg);
      checkRsp($sformatf("vec%0d", i), VECS[i].ab, VECS[i].lf, VECS[i].pg, VECS[i].lin);
    end

    // R8: idle cycle gives no response
    @(negedge clk);
    chk("idle rspValid R8", 32'(rspValid), 32'd0);
    chk("idle flags R8", 32'({faultAbsent, faultLimit, rspPhysValid}), 32'd0);

    // R1: load to slot 7 is ignored
    loadSeg(3'd7, 64'h0000_0000_0000_0000);
    access(3'd0, 32'h1234_5678, 1'b0);
    checkRsp("slot7 load ignored R1", 1'b0, 1'b0, 1'b0, 32'h1234_5678);

    // R9: same-cycle load and access sees old descriptor
    @(negedge clk);
    loadValid = 1'b1; loadSlot = 3'd1; loadDesc = 64'h0000_8050_0000_00FF;
    reqValid = 1'b1; reqSlot = 3'd1; reqOffset = 32'h0000_0800; pagingEn = 1'b0;
    @(negedge clk);
    loadValid = 1'b0; reqValid = 1'b0;
    checkRsp("same-cycle old R9", 1'b0, 1'b0, 1'b0, 32'h1234_5E78);

    // R1 R2 R3: reload took effect (base 0x500000, limit 0xFF bytes)
    access(3'd1, 32'h0000_00FF, 1'b0);
    checkRsp("reload at limit R1", 1'b0, 1'b0, 1'b0, 32'h0050_00FF);
    access(3'd1, 32'h0000_0100, 1'b0);
    checkRsp("reload past limit R3", 1'b0, 1'b1, 1'b0, 32'h0);

    // R10: reset in the middle empties slots
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    access(3'd2, 32'h0, 1'b0);
    checkRsp("post-reset slot2 R10", 1'b1, 1'b0, 1'b0, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule